// File: doc/BRIEF.md
# Burst Host Port to Native Memory Command Bridge

This block sits between a memory-mapped host port that issues bursts and a simple native memory-controller port. The host gives a start address and a beat count with either a read strobe or a write strobe, and a wait signal throttles it. The native side has three channels, each with a valid/ready handshake: commands (write flag plus word address), write data (data plus byte mask) and read data.

Every burst becomes one native command per beat. The address of each beat is the captured start address plus the beat index, counted in words. Commands and write beats go into two separate FIFOs. A small issue stage presents the two FIFO heads so that each write beat's data becomes valid in the same cycle as its command. It retires a head entry only after both of its handshakes have completed, in either order. Read data comes back on the host port in order, one valid pulse per beat. The native read channel is never stalled.

Top module: `avb_bridge`

## Requirements
- R1: After reset the host wait output is low, both native command valid and write-data valid are low, and the native read-data ready is high.
- R2: A write burst of N beats (N from 1 to 2^BURST_W-1) produces exactly N native commands with the write flag set (1), at addresses start+0 through start+N-1 in that order, and the k-th write-data transfer carries the k-th host data beat with its byte enables as the mask (bit i of the mask covers data bits 8i+7..8i).
- R3: A read burst is accepted in a single host cycle and produces exactly N native commands with the write flag clear (0), at addresses start+0 through start+N-1 in order; when N is greater than 1 the wait output is high in the cycle after acceptance.
- R4: While the native side keeps its ready signals high and the host presents beats back to back, the commands of one burst are accepted in consecutive cycles with no idle cycle between them.
- R5: Native write-data valid never rises unless command valid is high with the write flag set in that same cycle.
- R6: A command that is valid and not ready keeps its valid, address and write flag unchanged in the next cycle; once its handshake completes and no other command is queued, command valid is low in the following cycle.
- R7: Native read beats are returned on the host read-data output in arrival order, with one host read-valid pulse per native read beat.
- R8: The wait output is high whenever the command FIFO or the write-data FIFO is full; with CMD_DEPTH=4 and the command channel stalled, exactly 4 beats of a longer write burst are accepted, and once the stall ends the burst completes and wait returns low.
- R9: A new burst is not accepted while any command of the previous burst is still waiting for the native command channel; the wait output stays high in that time.
- R10: The command and write-data handshakes of one write beat may complete in different cycles; after the command alone is accepted, command valid stays low and write-data valid stays high until the data is accepted, and no later command is issued before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | ADDR_W | Burst start word address (taken from the first beat) |
| host_read | input | 1 | Read burst request |
| host_write | input | 1 | Write beat strobe |
| host_wdata | input | DATA_W | Write beat data |
| host_be | input | DATA_W/8 | Write beat byte enables |
| host_burstcount | input | BURST_W | Beats in the burst (1 or more, taken from the first beat) |
| host_wait | output | 1 | Host must hold its request |
| host_rdata | output | DATA_W | Read beat data |
| host_rvalid | output | 1 | Read beat valid |
| mem_cmd_valid | output | 1 | Native command valid |
| mem_cmd_ready | input | 1 | Native command ready |
| mem_cmd_we | output | 1 | Command write flag (1 write, 0 read) |
| mem_cmd_addr | output | ADDR_W | Command word address |
| mem_wd_valid | output | 1 | Native write-data valid |
| mem_wd_ready | input | 1 | Native write-data ready |
| mem_wd_data | output | DATA_W | Write data |
| mem_wd_mask | output | DATA_W/8 | Write byte mask |
| mem_rd_valid | input | 1 | Native read-data valid |
| mem_rd_ready | output | 1 | Native read-data ready (held high) |
| mem_rd_data | input | DATA_W | Native read data |

## Verification
A table of bursts drives single-beat, short, long and address-carrying reads and writes with both native readies held high. Per-beat address, data, mask and handshake cycle stamps separate a wrong address increment, a dropped or duplicated beat and an idle gap inside a burst. Directed runs then stall the command channel alone, which exercises the FIFO-full throttle and the hold of a pending command. They also stall the write-data channel alone, which shows whether the two handshakes of one beat are tracked apart. A queued single write followed by a read shows whether a new burst can overtake commands still outstanding.

// File: rtl/avb_pkg.sv
package avb_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RD   = 2'd1,
        SEQ_WR   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/avb_fifo.sv
module avb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [PW:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    assign head  = mem_q[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == (PW+1)'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = (st_q.wp == PW'(DEPTH-1)) ? '0 : st_q.wp + 1'b1;
        if (pop)  st_d.rp = (st_q.rp == PW'(DEPTH-1)) ? '0 : st_q.rp + 1'b1;
        unique case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp] <= push_data;
    end

endmodule

// File: rtl/avb_sequencer.sv
module avb_sequencer
    import avb_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_read,
    input  logic               host_write,
    input  logic [BURST_W-1:0] host_burstcount,
    input  logic               cmd_full,
    input  logic               cmd_empty,
    input  logic               wd_full,
    output logic               host_wait,
    output logic               cmd_push,
    output logic               cmd_push_we,
    output logic [ADDR_W-1:0]  cmd_push_addr,
    output logic               wd_push
);
    typedef struct packed {
        seq_state_e          state;
        logic [ADDR_W-1:0]   base;
        logic [BURST_W-1:0]  last;
        logic [BURST_W-1:0]  idx;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        cmd_push      = 1'b0;
        cmd_push_we   = 1'b0;
        cmd_push_addr = st_q.base + ADDR_W'(st_q.idx);

        // Throttle: full FIFOs, read issue in progress, or an idle bridge
        // whose previous commands have not all left yet.
        host_wait = cmd_full || wd_full || (st_q.state == SEQ_RD)
                 || ((st_q.state == SEQ_IDLE) && !cmd_empty);

        unique case (st_q.state)
            SEQ_IDLE: begin
                if (!host_wait && (host_read || host_write)) begin
                    cmd_push      = 1'b1;
                    cmd_push_we   = !host_read;
                    cmd_push_addr = host_addr;
                    st_d.base     = host_addr;
                    st_d.last     = host_burstcount - 1'b1;
                    st_d.idx      = BURST_W'(1);
                    if (host_burstcount > BURST_W'(1))
                        st_d.state = host_read ? SEQ_RD : SEQ_WR;
                end
            end
            SEQ_RD: begin
                if (!cmd_full) begin
                    cmd_push = 1'b1;
                    st_d.idx = st_q.idx + 1'b1;
                    if (st_q.idx == st_q.last) st_d.state = SEQ_IDLE;
                end
            end
            SEQ_WR: begin
                if (host_write && !host_wait) begin
                    cmd_push    = 1'b1;
                    cmd_push_we = 1'b1;
                    st_d.idx    = st_q.idx + 1'b1;
                    if (st_q.idx == st_q.last) st_d.state = SEQ_IDLE;
                end
            end
            default: st_d.state = SEQ_IDLE;
        endcase

        wd_push = cmd_push && cmd_push_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.state <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/avb_issue.sv
module avb_issue (
    input  logic clk,
    input  logic rst,
    input  logic cmd_empty,
    input  logic head_we,
    input  logic wd_empty,
    input  logic mem_cmd_ready,
    input  logic mem_wd_ready,
    output logic mem_cmd_valid,
    output logic mem_wd_valid,
    output logic cmd_pop,
    output logic wd_pop
);
    typedef struct packed {
        logic cmd_taken;
        logic wd_taken;
    } iss_st_t;

    iss_st_t st_d, st_q;

    logic head_ok, cmd_fire, wd_fire, cmd_done, wd_done, retire;

    always_comb begin
        // A write head is only offered once its data is also at hand.
        head_ok       = !cmd_empty && (!head_we || !wd_empty);
        mem_cmd_valid = head_ok && !st_q.cmd_taken;
        mem_wd_valid  = head_ok && head_we && !st_q.wd_taken;
        cmd_fire      = mem_cmd_valid && mem_cmd_ready;
        wd_fire       = mem_wd_valid && mem_wd_ready;
        cmd_done      = st_q.cmd_taken || cmd_fire;
        wd_done       = st_q.wd_taken || wd_fire;
        retire        = head_ok && cmd_done && (!head_we || wd_done);
        cmd_pop       = retire;
        wd_pop        = retire && head_we;

        st_d.cmd_taken = retire ? 1'b0 : cmd_done;
        st_d.wd_taken  = retire ? 1'b0 : wd_done;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/avb_bridge.sv
module avb_bridge #(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 64,
    parameter int BURST_W   = 8,
    parameter int CMD_DEPTH = 4,
    parameter int WD_DEPTH  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_read,
    input  logic                 host_write,
    input  logic [DATA_W-1:0]    host_wdata,
    input  logic [DATA_W/8-1:0]  host_be,
    input  logic [BURST_W-1:0]   host_burstcount,
    output logic                 host_wait,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 host_rvalid,
    output logic                 mem_cmd_valid,
    input  logic                 mem_cmd_ready,
    output logic                 mem_cmd_we,
    output logic [ADDR_W-1:0]    mem_cmd_addr,
    output logic                 mem_wd_valid,
    input  logic                 mem_wd_ready,
    output logic [DATA_W-1:0]    mem_wd_data,
    output logic [DATA_W/8-1:0]  mem_wd_mask,
    input  logic                 mem_rd_valid,
    output logic                 mem_rd_ready,
    input  logic [DATA_W-1:0]    mem_rd_data
);
    localparam int MASK_W = DATA_W / 8;
    localparam int CMD_W  = ADDR_W + 1;
    localparam int WD_W   = DATA_W + MASK_W;

    logic              cmd_push, cmd_push_we, wd_push;
    logic [ADDR_W-1:0] cmd_push_addr;
    logic              cmd_pop, wd_pop;
    logic              cmd_empty, cmd_full, wd_empty, wd_full;
    logic [CMD_W-1:0]  cmd_head;
    logic [WD_W-1:0]   wd_head;

    avb_sequencer #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) u_seq (
        .clk             (clk),
        .rst             (rst),
        .host_addr       (host_addr),
        .host_read       (host_read),
        .host_write      (host_write),
        .host_burstcount (host_burstcount),
        .cmd_full        (cmd_full),
        .cmd_empty       (cmd_empty),
        .wd_full         (wd_full),
        .host_wait       (host_wait),
        .cmd_push        (cmd_push),
        .cmd_push_we     (cmd_push_we),
        .cmd_push_addr   (cmd_push_addr),
        .wd_push         (wd_push)
    );

    avb_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (cmd_push),
        .push_data ({cmd_push_we, cmd_push_addr}),
        .pop       (cmd_pop),
        .head      (cmd_head),
        .empty     (cmd_empty),
        .full      (cmd_full)
    );

    avb_fifo #(.W(WD_W), .DEPTH(WD_DEPTH)) u_wd_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (wd_push),
        .push_data ({host_be, host_wdata}),
        .pop       (wd_pop),
        .head      (wd_head),
        .empty     (wd_empty),
        .full      (wd_full)
    );

    avb_issue u_issue (
        .clk           (clk),
        .rst           (rst),
        .cmd_empty     (cmd_empty),
        .head_we       (cmd_head[CMD_W-1]),
        .wd_empty      (wd_empty),
        .mem_cmd_ready (mem_cmd_ready),
        .mem_wd_ready  (mem_wd_ready),
        .mem_cmd_valid (mem_cmd_valid),
        .mem_wd_valid  (mem_wd_valid),
        .cmd_pop       (cmd_pop),
        .wd_pop        (wd_pop)
    );

    assign mem_cmd_we   = cmd_head[CMD_W-1];
    assign mem_cmd_addr = cmd_head[ADDR_W-1:0];
    assign mem_wd_data  = wd_head[DATA_W-1:0];
    assign mem_wd_mask  = wd_head[WD_W-1:DATA_W];

    // The host read path has no back-pressure, so beats pass straight on.
    assign mem_rd_ready = 1'b1;
    assign host_rvalid  = mem_rd_valid;
    assign host_rdata   = mem_rd_data;

endmodule

// File: rtl/avb_bridge_chk.sv
module avb_bridge_chk #(
    parameter int ADDR_W  = 24,
    parameter int BURST_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               host_read,
    input logic [BURST_W-1:0] host_burstcount,
    input logic               host_wait,
    input logic               mem_cmd_valid,
    input logic               mem_cmd_ready,
    input logic               mem_cmd_we,
    input logic [ADDR_W-1:0]  mem_cmd_addr,
    input logic               mem_wd_valid,
    input logic               mem_wd_ready,
    input logic               cmd_full,
    input logic               wd_full
);

    // R5: data never shows up ahead of, or apart from, its write command
    a_r5_wd_with_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wd_valid) |-> (mem_cmd_valid && mem_cmd_we));

    // R6: a stalled command holds still
    a_r6_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && !mem_cmd_ready) |=>
            (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_we)));

    // R3: a multi-beat read keeps the host waiting while it issues
    a_r3_rd_wait: assert property (@(posedge clk) disable iff (rst)
        (host_read && !host_wait && (host_burstcount > BURST_W'(1))) |=> host_wait);

    // R8: no beat is taken when a FIFO has no room
    a_r8_full_wait: assert property (@(posedge clk) disable iff (rst)
        (cmd_full || wd_full) |-> host_wait);

    // R10: command taken alone, data still owed: nothing else is issued
    a_r10_wd_owed: assert property (@(posedge clk) disable iff (rst)
        (mem_wd_valid && !mem_cmd_valid && !mem_wd_ready) |=>
            (mem_wd_valid && !mem_cmd_valid));

endmodule

bind avb_bridge avb_bridge_chk #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .host_read       (host_read),
    .host_burstcount (host_burstcount),
    .host_wait       (host_wait),
    .mem_cmd_valid   (mem_cmd_valid),
    .mem_cmd_ready   (mem_cmd_ready),
    .mem_cmd_we      (mem_cmd_we),
    .mem_cmd_addr    (mem_cmd_addr),
    .mem_wd_valid    (mem_wd_valid),
    .mem_wd_ready    (mem_wd_ready),
    .cmd_full        (cmd_full),
    .wd_full         (wd_full)
);

// File: tb/avb_bridge_tb.sv
`timescale 1ns/1ps
module avb_bridge_tb;
    localparam int AW = 24;
    localparam int DW = 64;
    localparam int BW = 8;
    localparam int MW = DW / 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic          host_read = 1'b0, host_write = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic [MW-1:0] host_be = '0;
    logic [BW-1:0] host_burstcount = BW'(1);
    logic          host_wait, host_rvalid;
    logic [DW-1:0] host_rdata;
    logic          mem_cmd_valid, mem_cmd_we, mem_wd_valid, mem_rd_ready;
    logic          mem_cmd_ready = 1'b1, mem_wd_ready = 1'b1;
    logic [AW-1:0] mem_cmd_addr;
    logic [DW-1:0] mem_wd_data;
    logic [MW-1:0] mem_wd_mask;
    logic          mem_rd_valid = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;

    avb_bridge u_dut (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_read(host_read), .host_write(host_write),
        .host_wdata(host_wdata), .host_be(host_be), .host_burstcount(host_burstcount),
        .host_wait(host_wait), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
        .mem_cmd_we(mem_cmd_we), .mem_cmd_addr(mem_cmd_addr),
        .mem_wd_valid(mem_wd_valid), .mem_wd_ready(mem_wd_ready),
        .mem_wd_data(mem_wd_data), .mem_wd_mask(mem_wd_mask),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_data(mem_rd_data)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    int nc = 0, nw = 0, nr = 0, r5_bad = 0;
    logic [AW-1:0] c_addr [256];
    logic          c_we   [256];
    int            c_cyc  [256];
    logic [DW-1:0] w_data [256];
    logic [MW-1:0] w_mask [256];
    logic [DW-1:0] r_data [256];
    logic          prev_wdv = 1'b0, pend_v = 1'b0;
    logic [DW-1:0] pend_d = '0;

    // Stimulus table: {write, start address, beats}
    localparam logic [32:0] VEC [6] = '{
        {1'b1, 24'h000100, 8'd4},
        {1'b0, 24'h000100, 8'd4},
        {1'b1, 24'h00FFFE, 8'd5},
        {1'b0, 24'h00FFFE, 8'd5},
        {1'b1, 24'h123456, 8'd1},
        {1'b0, 24'h000020, 8'd16}
    };

    function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
        logic [63:0] x;
        x = {40'd0, a};
        return 64'hC3A5_0000_0000_0000 ^ x ^ (x << 32);
    endfunction

    function automatic logic [DW-1:0] wbeat(input int v, input int b);
        return {32'(v) + 32'hD00D_0000, 32'(b) + 32'h0000_BEE0};
    endfunction

    function automatic logic [MW-1:0] wmask(input int v, input int b);
        return MW'((b * 37 + v * 11 + 1) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Native-side monitor and read responder (one-cycle read latency)
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (host_rvalid) begin
                r_data[nr] = host_rdata;
                nr++;
            end
            if (mem_cmd_valid && mem_cmd_ready) begin
                c_addr[nc] = mem_cmd_addr;
                c_we[nc]   = mem_cmd_we;
                c_cyc[nc]  = cyc;
                nc++;
            end
            if (mem_wd_valid && mem_wd_ready) begin
                w_data[nw] = mem_wd_data;
                w_mask[nw] = mem_wd_mask;
                nw++;
            end
            if (mem_wd_valid && !prev_wdv && !(mem_cmd_valid && mem_cmd_we)) r5_bad++;
            prev_wdv     = mem_wd_valid;
            mem_rd_valid = pend_v;
            mem_rd_data  = pend_d;
            pend_v       = mem_cmd_valid && mem_cmd_ready && !mem_cmd_we;
            pend_d       = memval(mem_cmd_addr);
        end
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    task automatic do_write(input logic [AW-1:0] a, input int n, input int v);
        for (int b = 0; b < n; b++) begin
            host_write      = 1'b1;
            host_addr       = a;
            host_burstcount = BW'(n);
            host_wdata      = wbeat(v, b);
            host_be         = wmask(v, b);
            @(negedge clk);
            while (host_wait) @(negedge clk);
            tick();
        end
        host_write = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input int n);
        host_read       = 1'b1;
        host_addr       = a;
        host_burstcount = BW'(n);
        @(negedge clk);
        while (host_wait) @(negedge clk);
        tick();
        host_read = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (host_wait || mem_cmd_valid || mem_wd_valid) @(negedge clk);
        repeat (3) tick();
    endtask

    initial begin
        int c0, w0, r0;
        repeat (3) tick();
        @(negedge clk);
        // R1: reset state
        chk(host_wait == 1'b0 && mem_cmd_valid == 1'b0 && mem_wd_valid == 1'b0 && mem_rd_ready == 1'b1,
            "R1 reset outputs", {host_wait, mem_cmd_valid, mem_wd_valid, mem_rd_ready}, 64'b0001);
        tick();
        rst = 1'b0;
        tick();
        @(negedge clk);
        chk(host_wait == 1'b0 && mem_cmd_valid == 1'b0, "R1 after release",
            {host_wait, mem_cmd_valid}, 64'b00);
        tick();

        // Table walk: R2, R3, R4, R7
        for (int i = 0; i < 6; i++) begin
            logic          we;
            logic [AW-1:0] a;
            int            n;
            we = VEC[i][32];
            a  = VEC[i][31:8];
            n  = int'(VEC[i][7:0]);
            c0 = nc; w0 = nw; r0 = nr;
            if (we) do_write(a, n, i);
            else    do_read(a, n);
            drain();
            chk(nc - c0 == n, we ? "R2 command count" : "R3 command count", 64'(nc - c0), 64'(n));
            for (int b = 0; b < n; b++) begin
                chk(c_addr[c0+b] == a + AW'(b) && c_we[c0+b] == we,
                    we ? "R2 address/flag" : "R3 address/flag",
                    {39'd0, c_we[c0+b], c_addr[c0+b]}, {39'd0, we, a + AW'(b)});
                chk(c_cyc[c0+b] == c_cyc[c0] + b, "R4 no gap", 64'(c_cyc[c0+b]), 64'(c_cyc[c0] + b));
                if (we) begin
                    chk(w_data[w0+b] == wbeat(i, b), "R2 data", w_data[w0+b], wbeat(i, b));
                    chk(w_mask[w0+b] == wmask(i, b), "R2 mask", 64'(w_mask[w0+b]), 64'(wmask(i, b)));
                end else begin
                    chk(r_data[r0+b] == memval(a + AW'(b)), "R7 read order",
                        r_data[r0+b], memval(a + AW'(b)));
                end
            end
            if (!we) chk(nr - r0 == n, "R7 one pulse per beat", 64'(nr - r0), 64'(n));
        end

        // R8 and R6: command channel stalled during an 8-beat write
        begin
            int k;
            k = 0; c0 = nc; w0 = nw;
            mem_cmd_ready = 1'b0;
            for (int t = 0; t < 12; t++) begin
                host_write = 1'b1; host_addr = 24'h000400; host_burstcount = BW'(8);
                host_wdata = wbeat(40, k); host_be = wmask(40, k);
                @(negedge clk);
                if (!host_wait) k++;
                tick();
            end
            host_write = 1'b0;
            @(negedge clk);
            chk(k == 4, "R8 beats taken while full", 64'(k), 64'd4);
            chk(host_wait == 1'b1, "R8 wait while full", 64'(host_wait), 64'd1);
            chk(mem_cmd_valid == 1'b1 && mem_cmd_addr == 24'h000400, "R6 stalled command held",
                {39'd0, mem_cmd_valid, mem_cmd_addr}, {39'd0, 1'b1, 24'h000400});
            tick();
            mem_cmd_ready = 1'b1;
            while (k < 8) begin
                host_write = 1'b1; host_wdata = wbeat(40, k); host_be = wmask(40, k);
                @(negedge clk);
                if (!host_wait) k++;
                tick();
            end
            host_write = 1'b0;
            drain();
            @(negedge clk);
            chk(host_wait == 1'b0, "R8 wait released", 64'(host_wait), 64'd0);
            chk(nc - c0 == 8 && nw - w0 == 8, "R8 burst completes", 64'(nc - c0), 64'd8);
            chk(c_addr[c0+7] == 24'h000407 && w_data[w0+7] == wbeat(40, 7), "R8 last beat",
                64'(c_addr[c0+7]), 64'h407);
            tick();
        end

        // R9: queued write blocks a new read burst
        c0 = nc;
        mem_cmd_ready = 1'b0;
        do_write(24'h000800, 1, 50);
        host_read = 1'b1; host_addr = 24'h000900; host_burstcount = BW'(1);
        repeat (5) tick();
        @(negedge clk);
        chk(host_wait == 1'b1, "R9 new burst held", 64'(host_wait), 64'd1);
        tick();
        mem_cmd_ready = 1'b1;
        @(negedge clk);
        while (host_wait) @(negedge clk);
        tick();
        host_read = 1'b0;
        drain();
        chk(nc - c0 == 2 && c_we[c0] == 1'b1 && c_we[c0+1] == 1'b0 && c_addr[c0+1] == 24'h000900,
            "R9 order write then read", 64'(nc - c0), 64'd2);

        // R10 and R6: data channel stalled alone
        c0 = nc; w0 = nw;
        mem_wd_ready = 1'b0;
        do_write(24'h000A00, 1, 60);
        host_write = 1'b1; host_addr = 24'h000B00; host_burstcount = BW'(1);
        host_wdata = wbeat(61, 0); host_be = wmask(61, 0);
        repeat (4) tick();
        @(negedge clk);
        chk(nc - c0 == 1, "R10 only one command issued", 64'(nc - c0), 64'd1);
        chk(mem_cmd_valid == 1'b0, "R6 valid drops after handshake", 64'(mem_cmd_valid), 64'd0);
        chk(mem_wd_valid == 1'b1 && mem_wd_data == wbeat(60, 0), "R10 data still offered",
            mem_wd_data, wbeat(60, 0));
        chk(host_wait == 1'b1, "R9 second write held", 64'(host_wait), 64'd1);
        tick();
        mem_wd_ready = 1'b1;
        @(negedge clk);
        while (host_wait) @(negedge clk);
        tick();
        host_write = 1'b0;
        drain();
        chk(nc - c0 == 2 && nw - w0 == 2 && c_addr[c0+1] == 24'h000B00 && w_data[w0+1] == wbeat(61, 0),
            "R10 both beats complete", 64'(nw - w0), 64'd2);

        chk(r5_bad == 0, "R5 data valid with command", 64'(r5_bad), 64'd0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule